// File: doc/BRIEF.md
# Multiplexed Gamepad Port Interface

This block sits on a console I/O bus and serves a small bank of byte registers for one or more controller ports. Each port owns a data register and a direction register. When the host reads a port, it gets one byte. The output bits of that byte come from the data register. The input bits come from the attached gamepad. Any input bit that nothing drives reads as 1.

The gamepad multiplexes its twelve buttons onto six pins. It chooses the group from the select line, which is bit 6 of the port byte. In three-button mode only that select line matters. In six-button mode a phase counter also counts rising edges of the select line written by the host. At later phases it exposes the extra buttons, and it returns to phase 0 after a programmable idle time.

The register bank also holds a fixed version byte. Every register that is not a port register works as plain read/write storage.

Top module: `pad_port_hub`

## Requirements
- R1: After reset, register index 0 always reads HW_VERSION. Every writable register reads 0x00 until it is written.
- R2: The register index is bus_addr[ADDR_W-1:1]. A write takes effect only when bus_wr is high and bus_addr[0] is 1 (odd byte address). Writes at even addresses, and writes to index 0, change nothing.
- R3: Indices from 1+2*NUM_PORTS upward, and the direction registers at 1+NUM_PORTS+p, read back the last byte written to them.
- R4: Port p's data register sits at index 1+p, and its read value is returned at that same index. Bit 7 and every bit whose direction bit is 1 come from the data register. All other bits come from the pad.
- R5: pad_btn groups 12 active-high bits per port, ordered from bit 11 down to bit 0 as M,X,Y,Z,Start,A,C,B,Right,Left,Down,Up. The pins are active-low. With select high and phase 0, pins 5..0 show C,B,Right,Left,Down,Up.
- R6: With select low and phase 0 or 1, pins 5..0 show Start,A,0,0,Down,Up.
- R7: The effective select is the data register's bit 6 when direction bit 6 is 1, and 1 (pull-up) otherwise. Pin 6 of the read value always equals the effective select.
- R8: In six-button mode (pad_mode 2'b10), each write that takes data bit 6 from 0 to 1 advances the phase, which saturates at 3. In any other mode the phase stays 0.
- R9: In six-button mode at phase 2 with select low, pins 3..0 read 0000 and pins 5..4 show Start,A.
- R10: At phase 3, select high gives pins 5..4 = C,B and pins 3..0 = M,X,Y,Z. Select low gives pins 5..4 = Start,A and pins 3..0 = 1111.
- R11: If TIMEOUT_CYC clock cycles pass without a write that changes data bit 6, the phase returns to 0.
- R12: With pad_mode 2'b00 or 2'b11, the pad is unconnected and every input bit of that port reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; bits above 0 select the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pad_btn | input | 12*NUM_PORTS | Active-high buttons, 12 per port |
| pad_mode | input | 2*NUM_PORTS | Per-port pad type: 00/11 none, 01 three-button, 10 six-button |

## Verification
The bench builds the block with NUM_PORTS = 2 and HW_VERSION = 0x5C. The two-port layout places the direction registers at indices 3 and 4, so storage begins at index 5 and part of the bank behaves as plain storage. The bench sets TIMEOUT_CYC to 40 instead of the default of several hundred thousand cycles. This puts the idle timeout, and the cycles just before and after it, within a short directed run. That same run also walks the full phase sequence, including saturation at phase 3.

// File: rtl/pad_port_pkg.sv
package pad_port_pkg;
   localparam int BTN_W = 12;

   typedef enum logic [1:0] {
      PAD_NONE     = 2'b00,
      PAD_3BTN     = 2'b01,
      PAD_6BTN     = 2'b10,
      PAD_NONE_ALT = 2'b11
   } pad_mode_e;

   typedef logic [1:0] pad_phase_t;
endpackage

// File: rtl/pad_phase_tracker.sv
module pad_phase_tracker
   import pad_port_pkg::*;
#(
   parameter int TIMEOUT_CYC = 375000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       six_mode,
   input  logic       th_wr,
   input  logic       th_new,
   input  logic       th_old,
   output pad_phase_t phase
);
   localparam int IDLE_W = $clog2(TIMEOUT_CYC + 1);
   localparam logic [IDLE_W-1:0] IDLE_MAX  = IDLE_W'(TIMEOUT_CYC);
   localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(TIMEOUT_CYC - 1);

   if (TIMEOUT_CYC < 2) begin : g_bad_timeout
      $error("pad_phase_tracker: TIMEOUT_CYC must be at least 2");
   end

   logic [IDLE_W-1:0] idle_q;
   logic              th_change;
   logic              th_rise;

   assign th_change = th_wr && (th_new != th_old);
   assign th_rise   = th_change && th_new;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_q <= IDLE_MAX;
         phase  <= 2'd0;
      end else if (!six_mode) begin
         idle_q <= IDLE_MAX;
         phase  <= 2'd0;
      end else if (th_change) begin
         idle_q <= '0;
         if (th_rise && phase != 2'd3)
            phase <= phase + 2'd1;
      end else if (idle_q != IDLE_MAX) begin
         idle_q <= idle_q + 1'b1;
         if (idle_q == IDLE_LAST)
            phase <= 2'd0;
      end
   end
endmodule

// File: rtl/pad_button_mux.sv
module pad_button_mux
   import pad_port_pkg::*;
(
   input  pad_mode_e        mode,
   input  pad_phase_t       phase,
   input  logic             th,
   input  logic [BTN_W-1:0] btn,
   output logic [7:0]       pad_val
);
   logic [BTN_W-1:0] n;
   assign n = ~btn;

   always_comb begin
      unique case (mode)
         PAD_3BTN, PAD_6BTN: begin
            if (th)
               pad_val = {1'b0, 1'b1, n[5:0]};
            else
               pad_val = {1'b0, 1'b0, n[7:6], 2'b00, n[1:0]};
            if (mode == PAD_6BTN) begin
               if (phase == 2'd2 && !th)
                  pad_val = {1'b0, 1'b0, n[7:6], 4'b0000};
               else if (phase == 2'd3)
                  pad_val = th ? {1'b0, 1'b1, n[5:4], n[11:8]}
                               : {1'b0, 1'b0, n[7:6], 4'b1111};
            end
         end
         default: pad_val = 8'hFF;
      endcase
   end
endmodule

// File: rtl/pad_pin_merge.sv
module pad_pin_merge (
   input  logic [7:0] pad_val,
   input  logic [7:0] data_r,
   input  logic [7:0] ctrl_eff,
   output logic [7:0] pin_val
);
   assign pin_val = (pad_val & ~ctrl_eff) | (data_r & ctrl_eff);
endmodule

// File: rtl/pad_port_hub.sv
module pad_port_hub
   import pad_port_pkg::*;
#(
   parameter int          NUM_PORTS   = 3,
   parameter int          REG_IDX_W   = 4,
   parameter logic [7:0]  HW_VERSION  = 8'hA0,
   parameter int          TIMEOUT_CYC = 375000,
   localparam int         ADDR_W      = REG_IDX_W + 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic                       bus_wr,
   input  logic [7:0]                 bus_wdata,
   output logic [7:0]                 bus_rdata,
   input  logic [BTN_W*NUM_PORTS-1:0] pad_btn,
   input  logic [2*NUM_PORTS-1:0]     pad_mode
);
   localparam int REG_NUM   = 1 << REG_IDX_W;
   localparam int CTRL_BASE = 1 + NUM_PORTS;

   if (NUM_PORTS < 1 || 1 + 2 * NUM_PORTS > REG_NUM) begin : g_bad_layout
      $error("pad_port_hub: port registers do not fit the register bank");
   end

   logic [7:0]             regs_q [REG_NUM];
   logic [REG_IDX_W-1:0]   idx;
   logic                   wr_odd;
   logic [8*REG_NUM-1:0]   reg_flat;
   logic [2*NUM_PORTS-1:0] phase_flat;
   logic [7:0]             port_rd [NUM_PORTS];

   assign idx    = bus_addr[ADDR_W-1:1];
   assign wr_odd = bus_wr && bus_addr[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < REG_NUM; i++) regs_q[i] <= 8'h00;
      end else if (wr_odd && idx != '0) begin
         regs_q[idx] <= bus_wdata;
      end
   end

   for (genvar r = 0; r < REG_NUM; r++) begin : g_flat
      assign reg_flat[8*r +: 8] = regs_q[r];
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      localparam logic [REG_IDX_W-1:0] DIDX = REG_IDX_W'(1 + p);
      localparam logic [REG_IDX_W-1:0] CIDX = REG_IDX_W'(CTRL_BASE + p);

      logic [7:0] data_r;
      logic [7:0] ctrl_eff;
      logic [7:0] pad_val;
      logic       th;
      logic       th_wr;
      pad_mode_e  mode;

      assign data_r   = regs_q[DIDX];
      assign ctrl_eff = regs_q[CIDX] | 8'h80;
      assign th       = ctrl_eff[6] ? data_r[6] : 1'b1;
      assign th_wr    = wr_odd && (idx == DIDX);
      assign mode     = pad_mode_e'(pad_mode[2*p +: 2]);

      pad_phase_tracker #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_phase (
         .clk      (clk),
         .rst_n    (rst_n),
         .six_mode (mode == PAD_6BTN),
         .th_wr    (th_wr),
         .th_new   (bus_wdata[6]),
         .th_old   (data_r[6]),
         .phase    (phase_flat[2*p +: 2])
      );

      pad_button_mux u_mux (
         .mode    (mode),
         .phase   (phase_flat[2*p +: 2]),
         .th      (th),
         .btn     (pad_btn[BTN_W*p +: BTN_W]),
         .pad_val (pad_val)
      );

      pad_pin_merge u_merge (
         .pad_val  (pad_val),
         .data_r   (data_r),
         .ctrl_eff (ctrl_eff),
         .pin_val  (port_rd[p])
      );
   end

   always_comb begin
      bus_rdata = regs_q[idx];
      if (idx == '0)
         bus_rdata = HW_VERSION;
      for (int p = 0; p < NUM_PORTS; p++)
         if (idx == REG_IDX_W'(1 + p))
            bus_rdata = port_rd[p];
   end
endmodule

// File: rtl/pad_port_hub_chk.sv
module pad_port_hub_chk #(
   parameter int         NUM_PORTS  = 3,
   parameter int         REG_IDX_W  = 4,
   parameter logic [7:0] HW_VERSION = 8'hA0,
   localparam int        ADDR_W     = REG_IDX_W + 1,
   localparam int        REG_NUM    = 1 << REG_IDX_W
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [ADDR_W-1:0]      bus_addr,
   input logic                   bus_wr,
   input logic [7:0]             bus_rdata,
   input logic [2*NUM_PORTS-1:0] pad_mode,
   input logic [2*NUM_PORTS-1:0] phase_flat,
   input logic [8*REG_NUM-1:0]   reg_flat
);
   assert_version_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr[ADDR_W-1:1] == '0) |-> (bus_rdata == HW_VERSION));

   assert_even_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_addr[0]) |=> $stable(reg_flat));

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
      assert_phase_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (phase_flat[2*p +: 2] == $past(phase_flat[2*p +: 2]))
               || (phase_flat[2*p +: 2] == 2'd0)
               || (($past(phase_flat[2*p +: 2]) != 2'd3)
                   && (phase_flat[2*p +: 2] == $past(phase_flat[2*p +: 2]) + 2'd1)));

      assert_phase_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (pad_mode[2*p +: 2] != 2'b10) |=> (phase_flat[2*p +: 2] == 2'd0));
   end
endmodule

bind pad_port_hub pad_port_hub_chk #(
   .NUM_PORTS  (NUM_PORTS),
   .REG_IDX_W  (REG_IDX_W),
   .HW_VERSION (HW_VERSION)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_wr     (bus_wr),
   .bus_rdata  (bus_rdata),
   .pad_mode   (pad_mode),
   .phase_flat (phase_flat),
   .reg_flat   (reg_flat)
);

// File: tb/tb_pad_port_hub.sv
module tb_pad_port_hub;
   localparam int         NP  = 2;
   localparam int         TO  = 40;
   localparam logic [7:0] VER = 8'h5C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [23:0] pad_btn = '0;
   logic [3:0]  pad_mode = '0;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pad_port_hub #(
      .NUM_PORTS(NP), .REG_IDX_W(4), .HW_VERSION(VER), .TIMEOUT_CYC(TO)
   ) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_btn(pad_btn), .pad_mode(pad_mode)
   );

   task automatic wr_reg(input int idx, input logic [7:0] v, input bit odd = 1'b1);
      @(negedge clk);
      bus_addr  = {4'(idx), odd};
      bus_wdata = v;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd_chk(input int idx, input logic [7:0] exp, input string tag);
      @(negedge clk);
      bus_addr = {4'(idx), 1'b0};
      #1;
      n_checks++;
      if (bus_rdata !== exp) begin
         n_fail++;
         $display("FAIL %s idx=%0d actual=%02h expected=%02h", tag, idx, bus_rdata, exp);
      end
   endtask

   task automatic t_reset;
      rd_chk(0, VER, "R1 version");
      rd_chk(7, 8'h00, "R1 storage reset");
      rd_chk(1, 8'h7F, "R12 unconnected reset read");
   endtask

   task automatic t_storage;
      wr_reg(5, 8'h99, 1'b0);
      rd_chk(5, 8'h00, "R2 even write ignored");
      wr_reg(5, 8'h99);
      rd_chk(5, 8'h99, "R2 odd write");
      wr_reg(0, 8'h12);
      rd_chk(0, VER, "R2 version not writable");
      wr_reg(15, 8'hA5);
      rd_chk(15, 8'hA5, "R3 top storage");
      wr_reg(4, 8'h3C);
      rd_chk(4, 8'h3C, "R3 direction readback");
      wr_reg(4, 8'h00);
   endtask

   task automatic t_three_button;
      pad_mode[1:0] = 2'b01;
      pad_btn[11:0] = 12'h0A1;       // Start, C, Up pressed
      wr_reg(3, 8'h00);
      rd_chk(1, 8'h5E, "R7 select pulled up");
      wr_reg(3, 8'h40);
      wr_reg(1, 8'h40);
      rd_chk(1, 8'h5E, "R5 select high group");
      wr_reg(1, 8'h00);
      rd_chk(1, 8'h12, "R6 select low group");
      wr_reg(1, 8'hC0);
      rd_chk(1, 8'hDE, "R4 bit7 from data");
      wr_reg(3, 8'h41);
      wr_reg(1, 8'h41);
      rd_chk(1, 8'h5F, "R4 output bit from data");
      wr_reg(3, 8'h40);
      for (int k = 0; k < 3; k++) begin
         wr_reg(1, 8'h00);
         wr_reg(1, 8'h40);
      end
      wr_reg(1, 8'h00);
      rd_chk(1, 8'h12, "R8 no phase in three-button mode");
   endtask

   task automatic t_unconnected;
      pad_mode[3:2] = 2'b00;
      pad_btn[23:12] = 12'hFFF;
      wr_reg(4, 8'h40);
      wr_reg(2, 8'h00);
      rd_chk(2, 8'h3F, "R12 unconnected select low");
      pad_mode[3:2] = 2'b11;
      wr_reg(2, 8'h40);
      rd_chk(2, 8'h7F, "R12 unconnected select high");
   endtask

   task automatic t_six_button;
      pad_mode[3:2] = 2'b10;
      pad_btn[23:12] = 12'hA40;      // M, Y, A pressed
      wr_reg(2, 8'h00);
      repeat (TO + 4) @(posedge clk);
      wr_reg(2, 8'h40);
      rd_chk(2, 8'h7F, "R8 phase1 select high");
      wr_reg(2, 8'h00);
      rd_chk(2, 8'h23, "R6 phase1 select low");
      wr_reg(2, 8'h40);
      rd_chk(2, 8'h7F, "R8 phase2 select high");
      wr_reg(2, 8'h00);
      rd_chk(2, 8'h20, "R9 phase2 select low");
      wr_reg(2, 8'h40);
      rd_chk(2, 8'h75, "R10 phase3 extra buttons");
      wr_reg(2, 8'h00);
      rd_chk(2, 8'h2F, "R10 phase3 select low");
      wr_reg(2, 8'h40);
      rd_chk(2, 8'h75, "R8 saturate at phase3");
      repeat (TO - 6) @(posedge clk);
      rd_chk(2, 8'h75, "R11 phase kept before timeout");
      repeat (8) @(posedge clk);
      rd_chk(2, 8'h7F, "R11 phase cleared by timeout");
      wr_reg(2, 8'h00);
      rd_chk(2, 8'h23, "R11 phase0 after timeout");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_storage();
      t_three_button();
      t_unconnected();
      t_six_button();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog all-requirements actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end
endmodule